// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block produces a single output pulse when a qualified trigger arrives. It has two trigger inputs with opposite active edges and an active-low clear input. A trigger is accepted in three cases:

- the active-rising input rises while the active-falling input is low;
- the active-falling input falls while the active-rising input is high;
- the clear input is released while both trigger inputs are already at their active levels.

Each pulse has two counted phases. A short discharge phase comes first, then a longer charge phase. The output stays high through both phases, so the pulse width in clock cycles is the sum of the two programmed lengths.

A new trigger during the charge phase restarts the discharge phase, which extends the pulse without a gap. A new trigger during the discharge phase is ignored. Driving clear low cancels a running pulse, forces the output low and blocks all triggers. All inputs must already be synchronous to the clock. Both phase lengths come from input ports, and each is captured at the moment its phase starts.

Top module: `retrig_mono`

## Requirements
- R1: A synchronous reset (`rst` high) returns the block to idle with `q_out` low. It also preloads the edge history so that no trigger is seen in the first cycle after reset.
- R2: A rising edge on `trig_rise` while `trig_fall_n` is low and `clr_n` is high is a trigger. `q_out` goes high at that same clock edge.
- R3: A falling edge on `trig_fall_n` while `trig_rise` is high and `clr_n` is high is a trigger.
- R4: A rising edge on `clr_n` while `trig_fall_n` is low and `trig_rise` is high is a trigger.
- R5: An edge on any input is not a trigger if the other inputs are not at the levels named in R2 to R4.
- R6: After a trigger from idle, `q_out` stays high for exactly max(`dis_len`,1) + max(`chg_len`,1) cycles, with no gap at the phase change, and then returns low.
- R7: A trigger at clock edge r (the first trigger is edge 0) that finds the block in the charge phase, including its last cycle, restarts the discharge phase. The total high time becomes r + D + C cycles, where D and C are the values from R6.
- R8: A trigger that finds the block in the discharge phase, including its last cycle, is ignored.
- R9: `clr_n` low at a clock edge forces `q_out` low after that edge and cancels any running phase.
- R10: While `clr_n` is low, edges on `trig_rise` and `trig_fall_n` have no effect.
- R11: `dis_len` is captured when the discharge phase starts and `chg_len` when the charge phase starts. Changing either port during its phase does not change the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_n | input | 1 | Trigger input, active on its falling edge |
| trig_rise | input | 1 | Trigger input, active on its rising edge |
| clr_n | input | 1 | Clear, active low; its rising edge can also trigger |
| dis_len | input | CNT_W | Discharge phase length in cycles (0 is treated as 1) |
| chg_len | input | CNT_W | Charge phase length in cycles (0 is treated as 1) |
| q_out | output | 1 | Registered pulse output |

## Verification
The bench places a retrigger on the last discharge cycle and another on the last charge cycle. A design that gets the phase boundary wrong by one cycle either stretches the first pulse or ends the second one early. It issues each trigger form with one qualifying level wrong, so an input that is decoded too loosely fires a pulse that should not exist. It clears during a pulse and then toggles the trigger inputs while clear is still held, which catches a clear that only stops the counter or that leaves the trigger path enabled. It also changes the length ports mid-phase, which exposes a design that reads the ports every cycle instead of capturing them.

// File: rtl/mono_pkg.sv
package mono_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIS  = 2'd1,
        PH_CHG  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pulse;
    } ctrl_s;

    localparam int unsigned EDGE_N = 3;

endpackage

// File: rtl/mono_edge.sv
module mono_edge
    import mono_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall_in,
    input  logic rise_in,
    input  logic clr_in,
    output logic trig_stb
);

    // bit 0: falling-active input, bit 1: rising-active input, bit 2: clear
    localparam logic [EDGE_N-1:0] PREV_RST = 3'b110;

    logic [EDGE_N-1:0] cur;
    logic [EDGE_N-1:0] prev_d, prev_q;
    logic              rise_edge, fall_edge, clr_edge;

    assign cur = {clr_in, rise_in, fall_in};

    always_comb begin
        prev_d    = cur;
        fall_edge = prev_q[0] & ~cur[0];
        rise_edge = ~prev_q[1] & cur[1];
        clr_edge  = ~prev_q[2] & cur[2];
        trig_stb  = cur[2] & ((~cur[0] & rise_edge)
                            | (cur[1] & fall_edge)
                            | (~cur[0] & cur[1] & clr_edge));
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_RST;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/mono_count.sv
module mono_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic [W-1:0] cnt_q,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (run) cnt_d = cnt_q - ONE;
        last = (cnt_q <= ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/retrig_mono.sv
module retrig_mono
    import mono_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_fall_n,
    input  logic             trig_rise,
    input  logic             clr_n,
    input  logic [CNT_W-1:0] dis_len,
    input  logic [CNT_W-1:0] chg_len,
    output logic             q_out
);

    ctrl_s            st_d, st_q;
    logic             trig_stb;
    logic             load_dis, load_chg, run;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_last;
    phase_e           phase_q;

    mono_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .fall_in  (trig_fall_n),
        .rise_in  (trig_rise),
        .clr_in   (clr_n),
        .trig_stb (trig_stb)
    );

    mono_count #(.W(CNT_W)) count_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load_dis | load_chg),
        .load_val (load_dis ? dis_len : chg_len),
        .run      (run),
        .cnt_q    (cnt_q),
        .last     (cnt_last)
    );

    always_comb begin
        st_d     = st_q;
        load_dis = 1'b0;
        load_chg = 1'b0;
        run      = 1'b0;
        if (!clr_n) begin
            st_d.phase = PH_IDLE;
            st_d.pulse = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (trig_stb) begin
                        st_d.phase = PH_DIS;
                        st_d.pulse = 1'b1;
                        load_dis   = 1'b1;
                    end
                end
                PH_DIS: begin
                    if (cnt_last) begin
                        st_d.phase = PH_CHG;
                        load_chg   = 1'b1;
                    end else begin
                        run = 1'b1;
                    end
                end
                PH_CHG: begin
                    if (trig_stb) begin
                        st_d.phase = PH_DIS;
                        load_dis   = 1'b1;
                    end else if (cnt_last) begin
                        st_d.phase = PH_IDLE;
                        st_d.pulse = 1'b0;
                    end else begin
                        run = 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.pulse = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_IDLE, pulse: 1'b0};
        else     st_q <= st_d;
    end

    assign phase_q = st_q.phase;
    assign q_out   = st_q.pulse;

endmodule

// File: rtl/mono_chk.sv
module mono_chk
    import mono_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         trig_stb,
    input logic         q_out,
    input phase_e       phase_q,
    input logic [W-1:0] cnt_q,
    input logic         cnt_last
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!q_out && phase_q == PH_IDLE));

    // R9
    clear_low_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (!q_out && phase_q == PH_IDLE));

    // R2
    rise_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(q_out) |-> $past(trig_stb));

    // R8
    dis_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && phase_q == PH_DIS && !cnt_last)
        |=> (phase_q == PH_DIS && q_out && cnt_q == $past(cnt_q) - W'(1)));

    // R7
    chg_retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && phase_q == PH_CHG && trig_stb) |=> (phase_q == PH_DIS && q_out));

    // R6
    chg_end_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && phase_q == PH_CHG && cnt_last && !trig_stb)
        |=> (!q_out && phase_q == PH_IDLE));

    // R6
    dis_to_chg_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && phase_q == PH_DIS && cnt_last) |=> (phase_q == PH_CHG && q_out));

endmodule

bind retrig_mono mono_chk #(.W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .trig_stb (trig_stb),
    .q_out    (q_out),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q),
    .cnt_last (cnt_last)
);

// File: tb/retrig_mono_tb.sv
`timescale 1ns/1ps
module retrig_mono_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fa = 1'b1;
    logic        rb = 1'b0;
    logic        cl = 1'b1;
    logic [15:0] dl = 16'd1;
    logic [15:0] cg = 16'd1;
    logic        q;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    retrig_mono #(.CNT_W(16)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_n (fa),
        .trig_rise   (rb),
        .clr_n       (cl),
        .dis_len     (dl),
        .chg_len     (cg),
        .q_out       (q)
    );

    typedef struct packed {
        logic [15:0] d;
        logic [15:0] c;
        logic [3:0]  pat;
        logic [15:0] exp_w;
    } vec_t;

    // pat 0..2: qualified triggers; 3..5: same edges with a wrong level
    localparam vec_t TBL [8] = '{
        '{16'd2, 16'd5,  4'd0, 16'd7},
        '{16'd1, 16'd1,  4'd1, 16'd2},
        '{16'd0, 16'd0,  4'd0, 16'd2},
        '{16'd3, 16'd9,  4'd2, 16'd12},
        '{16'd2, 16'd5,  4'd3, 16'd0},
        '{16'd2, 16'd5,  4'd4, 16'd0},
        '{16'd2, 16'd5,  4'd5, 16'd0},
        '{16'd4, 16'd20, 4'd1, 16'd24}
    };

    task automatic check(input int act, input int expv, input string tag);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // act: 0 none, 1 retrigger at sample k, 2 change lengths (R11),
    //      3 clear at k (R9), 4 clear at k then toggle inputs (R10), 5 reset at k (R1)
    task automatic run_case(input int d, input int c, input int pat, input int act,
                            input int k, input int expw, input string tag);
        int hi;
        @(negedge clk);
        fa = 1'b1; rb = 1'b0; cl = 1'b1; dl = 16'(d); cg = 16'(c);
        repeat (3) @(negedge clk);
        case (pat)
            0: begin fa = 1'b0; rb = 1'b0; end
            1: begin fa = 1'b1; rb = 1'b1; end
            2: begin fa = 1'b0; rb = 1'b1; cl = 1'b0; end
            3: begin fa = 1'b1; rb = 1'b0; end
            4: begin fa = 1'b1; rb = 1'b0; end
            default: begin fa = 1'b1; rb = 1'b1; cl = 1'b0; end
        endcase
        @(negedge clk);
        check(int'(q), 0, {tag, " pre"});
        case (pat)
            0, 3: rb = 1'b1;
            1, 4: fa = 1'b0;
            default: cl = 1'b1;
        endcase
        hi = 0;
        for (int i = 1; i <= expw + 8; i++) begin
            @(negedge clk);
            if (q) hi++;
            if (act == 1 && i == k - 1) rb = 1'b0;
            if (act == 1 && i == k)     rb = 1'b1;
            if (act == 2 && i == 1)     dl = 16'd40;
            if (act == 2 && i == k)     cg = 16'd40;
            if ((act == 3 || act == 4) && i == k) cl = 1'b0;
            if (act == 4 && i == k + 2) rb = 1'b0;
            if (act == 4 && i == k + 3) rb = 1'b1;
            if (act == 4 && i == k + 4) fa = 1'b1;
            if (act == 4 && i == k + 5) fa = 1'b0;
            if (act == 5 && i == k)     rst = 1'b1;
            if (act == 5 && i == k + 1) rst = 1'b0;
        end
        check(hi, expw, tag);
        check(int'(q), 0, {tag, " end"});
        rb = 1'b0; fa = 1'b1;
        @(negedge clk);
        cl = 1'b1;
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(q), 0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(int'(q), 0, "R1 after reset");

        for (int v = 0; v < 8; v++) begin
            string tg;
            case (TBL[v].pat)
                4'd0: tg = "R2 R6";
                4'd1: tg = "R3 R6";
                4'd2: tg = "R4 R6";
                default: tg = "R5";
            endcase
            run_case(int'(TBL[v].d), int'(TBL[v].c), int'(TBL[v].pat), 0, 0,
                     int'(TBL[v].exp_w), tg);
        end

        run_case(2, 10, 0, 1, 6, 18, "R7 mid charge");
        run_case(2, 4,  0, 1, 6, 12, "R7 last charge cycle");
        run_case(6, 4,  0, 1, 3, 10, "R8 mid discharge");
        run_case(3, 5,  0, 1, 3, 8,  "R8 last discharge cycle");
        run_case(3, 5,  0, 2, 4, 8,  "R11 lengths captured");
        run_case(2, 20, 0, 3, 5, 5,  "R9 clear mid pulse");
        run_case(2, 20, 0, 4, 4, 4,  "R10 triggers under clear");
        run_case(2, 20, 0, 5, 6, 6,  "R1 reset mid pulse");
        run_case(2, 3,  1, 0, 0, 5,  "R1 R3 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule